// File: doc/BRIEF.md
# Serial 1101 Detector with Moore and Mealy Outputs

The block watches a one-bit serial stream, sampled on each rising clock edge, for the pattern 1101. Two state machines run side by side on the same stream. One is a Moore machine whose flag depends only on its state. The other is a Mealy machine whose flag depends on its state and on the live input bit. Because both machines see the same bits, the one-cycle offset between the two output styles shows directly at the ports.

Detection overlaps. The trailing 1 of a match counts as the first bit of the next candidate, so the stream 1101101 gives two hits. Each machine also drives its current state code on a debug port. A synchronous, active-high reset returns both machines to their idle state.

Top module: `pattern_pair_detector`

## Requirements
- R1: When `rst` is high at a rising edge, both machines enter state code 0 at that edge, and both flags are low in the following cycle.
- R2: `mealy_hit` is high in the same cycle as the final 1 of a 1101 match, while that bit is still on `din`, and is low in every other cycle.
- R3: `moore_hit` is high exactly one cycle after `mealy_hit` is high, and only while `moore_state` holds code 4.
- R4: Matches overlap. The stream 1101101 yields two Mealy hits, on the 4th and 7th bits, and two Moore hits, each one cycle after its Mealy hit.
- R5: After a reset, the stream 1,1,1,0,1,1,0,1,0 drives `moore_state` through the codes 1,2,2,3,4,2,3,4,0, one code after each bit.
- R6: For the same stream, `mealy_state` moves through the codes 1,2,2,3,1,2,3,1,0. The Mealy codes are 0 for idle, 1 for seen 1, 2 for seen 11 and 3 for seen 110.
- R7: A reset in the middle of a stream discards any partial match. The bits 1,1,0, then a reset, then 1 give no hit.
- R8: Over long pseudo-random streams with resets in between, `mealy_hit` equals (the previous three bits since reset were 1,1,0 and `din` is 1), and `moore_hit` equals the previous cycle's `mealy_hit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial data bit |
| moore_hit | output | 1 | Moore detect flag, registered through the state |
| mealy_hit | output | 1 | Mealy detect flag, combinational from state and `din` |
| moore_state | output | STATE_W | Moore state code, 0 to 4 |
| mealy_state | output | STATE_W | Mealy state code, 0 to 3 |

## Verification
A wrong transition in either machine shows on its debug state port at the very next edge. It also shows at the flags at the latest when the next 1101 completes: the Mealy flag goes wrong in that same cycle and the Moore flag one cycle later. A fault that affects only one machine breaks the fixed one-cycle relation between the two flags, so comparing the two flags with each other exposes it within one cycle of the affected match. The directed state traces find errors on arcs that no match uses.

// File: rtl/pd_pkg.sv
`timescale 1ns/1ps
package pd_pkg;
   // minimum state register width able to hold five codes
   localparam int ST_W = 3;
   // state code values shared by both machines
   localparam int C_IDLE = 0;
   localparam int C_ONE  = 1;
   localparam int C_TWO  = 2;
   localparam int C_ZERO = 3;
   localparam int C_DONE = 4;
endpackage

// File: rtl/pd_moore.sv
`timescale 1ns/1ps
module pd_moore #(
   parameter int W = pd_pkg::ST_W
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         din,
   output logic         hit,
   output logic [W-1:0] state
);
   localparam logic [W-1:0] S0 = W'(pd_pkg::C_IDLE);
   localparam logic [W-1:0] S1 = W'(pd_pkg::C_ONE);
   localparam logic [W-1:0] S2 = W'(pd_pkg::C_TWO);
   localparam logic [W-1:0] S3 = W'(pd_pkg::C_ZERO);
   localparam logic [W-1:0] S4 = W'(pd_pkg::C_DONE);

   logic [W-1:0] nxt;

   always_comb begin
      case (state)
         S0:      nxt = din ? S1 : S0;
         S1:      nxt = din ? S2 : S0;
         S2:      nxt = din ? S2 : S3;
         S3:      nxt = din ? S4 : S0;
         S4:      nxt = din ? S2 : S0;
         default: nxt = S0;
      endcase
   end

   always_comb begin
      case (state)
         S4:      hit = 1'b1;
         default: hit = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state <= S0;
      else     state <= nxt;
   end
endmodule

// File: rtl/pd_mealy.sv
`timescale 1ns/1ps
module pd_mealy #(
   parameter int W = pd_pkg::ST_W
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         din,
   output logic         hit,
   output logic [W-1:0] state
);
   localparam logic [W-1:0] S0 = W'(pd_pkg::C_IDLE);
   localparam logic [W-1:0] S1 = W'(pd_pkg::C_ONE);
   localparam logic [W-1:0] S2 = W'(pd_pkg::C_TWO);
   localparam logic [W-1:0] S3 = W'(pd_pkg::C_ZERO);

   logic [W-1:0] nxt;

   always_comb begin
      case (state)
         S0:      nxt = din ? S1 : S0;
         S1:      nxt = din ? S2 : S0;
         S2:      nxt = din ? S2 : S3;
         S3:      nxt = din ? S1 : S0;
         default: nxt = S0;
      endcase
   end

   always_comb begin
      case (state)
         S3:      hit = din;
         default: hit = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state <= S0;
      else     state <= nxt;
   end
endmodule

// File: rtl/pattern_pair_detector.sv
`timescale 1ns/1ps
module pattern_pair_detector #(
   parameter int STATE_W = pd_pkg::ST_W
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               din,
   output logic               moore_hit,
   output logic               mealy_hit,
   output logic [STATE_W-1:0] moore_state,
   output logic [STATE_W-1:0] mealy_state
);
   if (STATE_W < pd_pkg::ST_W) begin : g_width_bad
      $error("pattern_pair_detector: STATE_W must be at least %0d", pd_pkg::ST_W);
   end

   pd_moore #(.W(STATE_W)) u_moore (
      .clk   (clk),
      .rst   (rst),
      .din   (din),
      .hit   (moore_hit),
      .state (moore_state)
   );

   pd_mealy #(.W(STATE_W)) u_mealy (
      .clk   (clk),
      .rst   (rst),
      .din   (din),
      .hit   (mealy_hit),
      .state (mealy_state)
   );
endmodule

// File: rtl/pd_chk.sv
`timescale 1ns/1ps
module pd_chk #(
   parameter int W = pd_pkg::ST_W
) (
   input logic         clk,
   input logic         rst,
   input logic         din,
   input logic         moore_hit,
   input logic         mealy_hit,
   input logic [W-1:0] moore_state,
   input logic [W-1:0] mealy_state
);
   // R1
   reset_idle_chk: assert property (@(posedge clk)
      rst |=> (moore_state == '0 && mealy_state == '0));

   // R3
   moore_follows_chk: assert property (@(posedge clk) disable iff (rst)
      mealy_hit |=> moore_hit);

   // R3
   moore_no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
      !mealy_hit |=> !moore_hit);

   // R4
   overlap_restart_chk: assert property (@(posedge clk) disable iff (rst)
      mealy_hit |=> (mealy_state == W'(pd_pkg::C_ONE)));

   // R2
   mealy_needs_one_chk: assert property (@(posedge clk) disable iff (rst)
      mealy_hit |-> (din && moore_state == W'(pd_pkg::C_ZERO)));

   // R5
   moore_range_chk: assert property (@(posedge clk) disable iff (rst)
      moore_state <= W'(pd_pkg::C_DONE));

   // R6
   mealy_range_chk: assert property (@(posedge clk) disable iff (rst)
      mealy_state <= W'(pd_pkg::C_ZERO));
endmodule

bind pattern_pair_detector pd_chk #(.W(STATE_W)) u_pd_chk (
   .clk         (clk),
   .rst         (rst),
   .din         (din),
   .moore_hit   (moore_hit),
   .mealy_hit   (mealy_hit),
   .moore_state (moore_state),
   .mealy_state (mealy_state)
);

// File: tb/pattern_pair_detector_bench.sv
`timescale 1ns/100ps
module pattern_pair_detector_bench;
   localparam int W = 3;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         din = 1'b0;
   logic         moore_hit, mealy_hit;
   logic [W-1:0] moore_state, mealy_state;

   int   n_cmp = 0;
   int   n_bad = 0;
   logic [2:0] hist = 3'b000;
   logic prev_me = 1'b0;
   int   me_hits = 0;
   int   mo_hits = 0;

   always #2.5 clk = ~clk;

   pattern_pair_detector #(.STATE_W(W)) u_pattern_pair_detector (
      .clk(clk), .rst(rst), .din(din),
      .moore_hit(moore_hit), .mealy_hit(mealy_hit),
      .moore_state(moore_state), .mealy_state(mealy_state)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // drive one bit and compare both flags with the reference model
   task automatic step(input logic b, input string req);
      logic exp_me;
      @(negedge clk);
      din = b;
      #1;
      exp_me = (hist == 3'b110) && b;
      chk({req, " mealy_hit"}, int'(mealy_hit), int'(exp_me));
      chk({req, " moore_hit"}, int'(moore_hit), int'(prev_me));
      if (mealy_hit) me_hits++;
      if (moore_hit) mo_hits++;
      prev_me = exp_me;
      hist    = {hist[1:0], b};
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      din = 1'b0;
      @(posedge clk);
      #1;
      rst = 1'b0;
      hist    = 3'b000;
      prev_me = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 moore_state", int'(moore_state), 0);
      chk("R1 mealy_state", int'(mealy_state), 0);
      chk("R1 moore_hit", int'(moore_hit), 0);
      chk("R1 mealy_hit", int'(mealy_hit), 0);
   endtask

   task automatic t_trace();
      logic [8:0] bits = 9'b111011010;
      int mo_exp[9] = '{1, 2, 2, 3, 4, 2, 3, 4, 0};
      int me_exp[9] = '{1, 2, 2, 3, 1, 2, 3, 1, 0};
      do_reset();
      for (int i = 0; i < 9; i++) begin
         step(bits[8-i], "R2");
         @(posedge clk);
         #1;
         chk("R5 moore_state", int'(moore_state), mo_exp[i]);
         chk("R6 mealy_state", int'(mealy_state), me_exp[i]);
         if (i == 4 || i == 7)
            chk("R3 moore_hit in code 4", int'(moore_hit), 1);
      end
   endtask

   task automatic t_overlap();
      logic [6:0] bits = 7'b1101101;
      do_reset();
      me_hits = 0;
      mo_hits = 0;
      for (int i = 0; i < 7; i++) step(bits[6-i], "R4");
      step(1'b0, "R4");
      chk("R4 mealy hit count", me_hits, 2);
      chk("R4 moore hit count", mo_hits, 2);
   endtask

   task automatic t_midreset();
      do_reset();
      step(1'b1, "R7");
      step(1'b1, "R7");
      step(1'b0, "R7");
      do_reset();
      step(1'b1, "R7");
      chk("R7 no hit after reset", int'(mealy_hit), 0);
      step(1'b0, "R7");
      chk("R7 no late moore hit", int'(moore_hit), 0);
   endtask

   task automatic t_random();
      do_reset();
      for (int i = 0; i < 3000; i++) begin
         if (i % 397 == 396) do_reset();
         step(($urandom % 4) != 0, "R8");
      end
   endtask

   initial begin
      #1000000;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd7));
      t_reset();
      t_trace();
      t_overlap();
      t_midreset();
      t_random();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule